// File: doc/BRIEF.md
# I2C Receive Wait and Interrupt Controller

This block sits beside an I2C byte shifter. It decides when the bus-interface interrupt is raised and when SCL is held low. Its inputs are synchronized SCL falling-edge strobes, the shifter's bit index, START and STOP detect strobes and the transfer direction. It also takes CPU write strobes for the data, control, configuration and status registers. Its outputs are an active-low pending flag, a one-cycle interrupt pulse, an open-drain style SCL hold request and a readable wait flag.

The feature that sets it apart is an optional pause on received data bytes. After the last data bit and before the ACK clock, the block raises an interrupt and stretches SCL, so software can pick ACK or NACK before the acknowledge is clocked. Software then releases the bus through the status register, and a second interrupt follows on the ACK clock falling edge. The wait flag is set by a data write and cleared by a control write. Software reads it to tell the two interrupt points apart. An interrupt on STOP can also be enabled.

Top module: `i2c_rxwait_ctrl`

## Requirements
- R1: After reset, pend_n=1, irq=0, scl_hold=0, wait_flag=0, wr_err=0 and ack_bit=0.
- R2: A stop_det strobe with stop interrupt enabled gives irq=1 for exactly one cycle on the next clock edge and leaves pend_n unchanged. With it disabled, no irq is raised.
- R3: With wait enable=1 and ACK-clock mode=1, while receiving a data byte (xmit=0, not the address byte), an scl_fall with bit_idx=7 gives, on the next edge, a one-cycle irq, pend_n=0 and scl_hold=1. scl_hold stays 1 until it is released.
- R4: A status write with stat_pend=1 sets pend_n=1 and clears scl_hold on the next edge. A status write with stat_pend=0 has no effect.
- R5: In ACK-clock mode, an scl_fall with bit_idx=8 gives a one-cycle irq and pend_n=0 in every direction and phase, without holding SCL.
- R6: With ACK-clock mode=0, the interrupt comes on the scl_fall with bit_idx=7 whatever the wait enable is, SCL is never held, and an scl_fall with bit_idx=8 raises nothing.
- R7: A data write in receive mode outside the address byte sets wait_flag to 1. A control write clears it and latches ack_bit and the ACK-clock mode from its data inputs.
- R8: In transmit mode (xmit=1), and in the address byte from start_det until that byte's interrupt edge, wait_flag stays 0 and no interrupt occurs at bit_idx=7 in ACK-clock mode.
- R9: A data write while scl_hold=1 leaves wait_flag and scl_hold unchanged and sets the sticky wr_err, which only reset clears.
- R10: stop_det clears scl_hold and wait_flag and ends any address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_fall | input | 1 | One-cycle strobe on a synchronized SCL falling edge |
| bit_idx | input | 4 | Clock index in the current byte frame: 0..7 data, 8 ACK |
| start_det | input | 1 | START condition detected strobe |
| stop_det | input | 1 | STOP condition detected strobe |
| xmit | input | 1 | 1 = transmitting, 0 = receiving |
| wr_data | input | 1 | CPU write strobe to the data register |
| wr_ctrl | input | 1 | CPU write strobe to the control register |
| ctrl_ack_clk | input | 1 | Control write data: ACK-clock mode |
| ctrl_ack_bit | input | 1 | Control write data: ACK level to drive (0 = ACK) |
| wr_cfg | input | 1 | CPU write strobe to the configuration register |
| cfg_stop_ie | input | 1 | Configuration data: interrupt on STOP enable |
| cfg_wait_ie | input | 1 | Configuration data: pre-ACK wait enable |
| wr_stat | input | 1 | CPU write strobe to the status register |
| stat_pend | input | 1 | Status write data: 1 releases the pending flag |
| pend_n | output | 1 | Pending-interrupt flag, active low |
| irq | output | 1 | One-cycle interrupt request pulse |
| scl_hold | output | 1 | 1 = pull SCL low |
| wait_flag | output | 1 | Readable wait flag |
| ack_bit | output | 1 | Latched ACK choice for the shifter |
| wr_err | output | 1 | Sticky flag: data written during a pre-ACK hold |

## Verification
The bench checks that the address byte after START and transmit bytes never pause at bit 7. A design that skipped the address-phase or direction gating would stall the bus where no software handler expects it. It also walks the full pause, control write, release and ACK sequence, checking the wait flag at each step. A swapped set or clear source would make the two interrupts indistinguishable. A STOP that lands during a hold must release SCL and still leave pend_n alone. Separate checks cover a data write during the hold, which must not disturb the wait, and the no-ACK-clock mode, where the wait enable must have no effect.

// File: rtl/i2c_rxw_pkg.sv
package i2c_rxw_pkg;
  typedef struct packed {
    logic pre_ack;  // last data bit fell, pause before ACK clock
    logic byte_end; // byte completion interrupt point
    logic stop;     // stop condition seen
  } rxw_evt_t;
endpackage

// File: rtl/i2c_rxw_cfg_flags.sv
module i2c_rxw_cfg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic xmit,
  input  logic byte_end,
  input  logic hold_q,
  input  logic wr_data,
  input  logic wr_ctrl,
  input  logic ctrl_ack_clk,
  input  logic ctrl_ack_bit,
  input  logic wr_cfg,
  input  logic cfg_stop_ie,
  input  logic cfg_wait_ie,
  output logic stop_ie,
  output logic wait_eff,
  output logic ack_clk,
  output logic ack_bit,
  output logic addr_phase,
  output logic wait_flag,
  output logic wr_err
);
  logic stop_ie_q, wait_ie_q, ack_clk_q, ack_bit_q;
  logic stop_ie_d, wait_ie_d, ack_clk_d, ack_bit_d;
  logic addr_q, addr_d, wait_q, wait_d, err_q, err_d;
  logic data_ok;

  assign data_ok = wr_data & ~hold_q;

  always_comb begin
    stop_ie_d = stop_ie_q;
    wait_ie_d = wait_ie_q;
    ack_clk_d = ack_clk_q;
    ack_bit_d = ack_bit_q;
    if (wr_cfg) begin
      stop_ie_d = cfg_stop_ie;
      wait_ie_d = cfg_wait_ie;
    end
    if (wr_ctrl) begin
      ack_clk_d = ctrl_ack_clk;
      ack_bit_d = ctrl_ack_bit;
    end
  end

  always_comb begin
    addr_d = addr_q;
    if (byte_end) addr_d = 1'b0;
    if (start_det) addr_d = 1'b1;
    if (stop_det) addr_d = 1'b0;

    wait_d = wait_q;
    if (data_ok && !xmit && !addr_q) wait_d = 1'b1;
    if (wr_ctrl) wait_d = 1'b0;
    if (start_det || stop_det) wait_d = 1'b0;

    err_d = err_q | (wr_data & hold_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_ie_q <= 1'b0;
      wait_ie_q <= 1'b0;
      ack_clk_q <= 1'b0;
      ack_bit_q <= 1'b0;
      addr_q    <= 1'b0;
      wait_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      stop_ie_q <= stop_ie_d;
      wait_ie_q <= wait_ie_d;
      ack_clk_q <= ack_clk_d;
      ack_bit_q <= ack_bit_d;
      addr_q    <= addr_d;
      wait_q    <= wait_d;
      err_q     <= err_d;
    end
  end

  assign stop_ie    = stop_ie_q;
  assign wait_eff   = wait_ie_q & ack_clk_q;
  assign ack_clk    = ack_clk_q;
  assign ack_bit    = ack_bit_q;
  assign addr_phase = addr_q;
  assign wait_flag  = wait_q;
  assign wr_err     = err_q;
endmodule

// File: rtl/i2c_rxw_event.sv
module i2c_rxw_event
  import i2c_rxw_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int IDX_W     = 4
) (
  input  logic             scl_fall,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             stop_det,
  input  logic             xmit,
  input  logic             ack_clk,
  input  logic             wait_eff,
  input  logic             addr_phase,
  output rxw_evt_t         evt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);
  localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(DATA_BITS);

  logic at_last, at_ack;

  assign at_last = scl_fall && (bit_idx == LAST_IDX);
  assign at_ack  = scl_fall && (bit_idx == ACK_IDX);

  always_comb begin
    evt.pre_ack  = at_last & wait_eff & ~xmit & ~addr_phase;
    evt.byte_end = ack_clk ? at_ack : at_last;
    evt.stop     = stop_det;
  end
endmodule

// File: rtl/i2c_rxw_intr.sv
module i2c_rxw_intr
  import i2c_rxw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rxw_evt_t evt,
  input  logic     stop_ie,
  input  logic     wr_stat,
  input  logic     stat_pend,
  output logic     pend_n,
  output logic     irq,
  output logic     scl_hold
);
  logic pend_q, pend_d, irq_q, irq_d, hold_q, hold_d;

  always_comb begin
    pend_d = pend_q;
    hold_d = hold_q;
    irq_d  = 1'b0;
    if (wr_stat && stat_pend) begin
      pend_d = 1'b1;
      hold_d = 1'b0;
    end
    if (evt.pre_ack) begin
      pend_d = 1'b0;
      hold_d = 1'b1;
      irq_d  = 1'b1;
    end
    if (evt.byte_end) begin
      pend_d = 1'b0;
      irq_d  = 1'b1;
    end
    if (evt.stop) begin
      hold_d = 1'b0;
      if (stop_ie) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      irq_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
      hold_q <= hold_d;
    end
  end

  assign pend_n   = pend_q;
  assign irq      = irq_q;
  assign scl_hold = hold_q;
endmodule

// File: rtl/i2c_rxwait_ctrl.sv
module i2c_rxwait_ctrl
  import i2c_rxw_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int IDX_W     = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_fall,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             xmit,
  input  logic             wr_data,
  input  logic             wr_ctrl,
  input  logic             ctrl_ack_clk,
  input  logic             ctrl_ack_bit,
  input  logic             wr_cfg,
  input  logic             cfg_stop_ie,
  input  logic             cfg_wait_ie,
  input  logic             wr_stat,
  input  logic             stat_pend,
  output logic             pend_n,
  output logic             irq,
  output logic             scl_hold,
  output logic             wait_flag,
  output logic             ack_bit,
  output logic             wr_err
);
  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_sync_n;
  rxw_evt_t            evt;
  logic                stop_ie, wait_eff, ack_clk, addr_phase, hold_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_LEN-1];

  i2c_rxw_cfg_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n), .start_det(start_det), .stop_det(stop_det),
    .xmit(xmit), .byte_end(evt.byte_end), .hold_q(hold_int),
    .wr_data(wr_data), .wr_ctrl(wr_ctrl), .ctrl_ack_clk(ctrl_ack_clk),
    .ctrl_ack_bit(ctrl_ack_bit), .wr_cfg(wr_cfg), .cfg_stop_ie(cfg_stop_ie),
    .cfg_wait_ie(cfg_wait_ie), .stop_ie(stop_ie), .wait_eff(wait_eff),
    .ack_clk(ack_clk), .ack_bit(ack_bit), .addr_phase(addr_phase),
    .wait_flag(wait_flag), .wr_err(wr_err)
  );

  i2c_rxw_event #(.DATA_BITS(DATA_BITS), .IDX_W(IDX_W)) u_event (
    .scl_fall(scl_fall), .bit_idx(bit_idx), .stop_det(stop_det), .xmit(xmit),
    .ack_clk(ack_clk), .wait_eff(wait_eff), .addr_phase(addr_phase), .evt(evt)
  );

  i2c_rxw_intr u_intr (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt), .stop_ie(stop_ie),
    .wr_stat(wr_stat), .stat_pend(stat_pend), .pend_n(pend_n), .irq(irq),
    .scl_hold(hold_int)
  );

  assign scl_hold = hold_int;
endmodule

module i2c_rxwait_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_fall,
  input logic stop_det,
  input logic xmit,
  input logic wr_data,
  input logic wr_ctrl,
  input logic wr_stat,
  input logic stat_pend,
  input logic stop_ie,
  input logic pre_ack,
  input logic pend_n,
  input logic irq,
  input logic scl_hold,
  input logic wait_flag,
  input logic wr_err
);
  a_r3_pre_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ack && !stop_det |=> irq && !pend_n && scl_hold);

  a_r2_stop_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && stop_ie && !scl_fall && !wr_stat |=> irq && (pend_n == $past(pend_n)));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && stat_pend && !scl_fall |=> pend_n && !scl_hold);

  a_r10_stop_unholds: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !scl_hold && !wait_flag);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && scl_hold |=> wr_err);

  a_r9_wait_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && scl_hold && !wr_ctrl && !stop_det && !scl_fall
    |=> wait_flag == $past(wait_flag));

  a_r7_wait_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_flag) |-> $past(wr_data && !xmit));

  a_r9_err_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_err) |-> wr_err);
endmodule

bind i2c_rxwait_ctrl i2c_rxwait_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_fall(scl_fall), .stop_det(stop_det),
  .xmit(xmit), .wr_data(wr_data), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
  .stat_pend(stat_pend), .stop_ie(stop_ie), .pre_ack(evt.pre_ack),
  .pend_n(pend_n), .irq(irq), .scl_hold(scl_hold), .wait_flag(wait_flag),
  .wr_err(wr_err)
);

// File: tb/i2c_rxwait_ctrl_tb.sv
module i2c_rxwait_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic scl_fall, start_det, stop_det, xmit, wr_data, wr_ctrl, ctrl_ack_clk;
  logic ctrl_ack_bit, wr_cfg, cfg_stop_ie, cfg_wait_ie, wr_stat, stat_pend;
  logic [3:0] bit_idx;
  logic pend_n, irq, scl_hold, wait_flag, ack_bit, wr_err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_rxwait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .bit_idx(bit_idx),
    .start_det(start_det), .stop_det(stop_det), .xmit(xmit), .wr_data(wr_data),
    .wr_ctrl(wr_ctrl), .ctrl_ack_clk(ctrl_ack_clk), .ctrl_ack_bit(ctrl_ack_bit),
    .wr_cfg(wr_cfg), .cfg_stop_ie(cfg_stop_ie), .cfg_wait_ie(cfg_wait_ie),
    .wr_stat(wr_stat), .stat_pend(stat_pend), .pend_n(pend_n), .irq(irq),
    .scl_hold(scl_hold), .wait_flag(wait_flag), .ack_bit(ack_bit), .wr_err(wr_err)
  );

  // vector: [14]fall [13:10]idx [9]start [8]stop [7]xmit [6]wr_data [5]wr_ctrl
  //         [4]wr_stat(pend=1) | expected [3]irq [2]pend_n [1]scl_hold [0]wait_flag
  localparam int NV = 22;
  localparam logic [14:0] VEC [NV] = '{
    15'b0_0000_1_0_0_0_0_0_0100, // R8 start: address phase
    15'b0_0000_0_0_0_1_0_0_0100, // R8 data write in address byte
    15'b1_0111_0_0_0_0_0_0_0100, // R8 no pause in address byte
    15'b1_1000_0_0_0_0_0_0_1000, // R5 ACK edge interrupt
    15'b0_0000_0_0_0_0_0_1_0100, // R4 release
    15'b0_0000_0_0_0_1_0_0_0101, // R7 data write sets wait
    15'b1_0011_0_0_0_0_0_0_0101, // R3 mid-byte edge, nothing
    15'b1_0111_0_0_0_0_0_0_1011, // R3 pre-ACK pause
    15'b0_0000_0_0_0_0_0_0_0011, // R3 hold persists, irq one cycle
    15'b0_0000_0_0_0_1_0_0_0011, // R9 data write during hold ignored
    15'b0_0000_0_0_0_0_1_0_0010, // R7 control write clears wait
    15'b0_0000_0_0_0_0_0_1_0100, // R4 release frees SCL
    15'b1_1000_0_0_0_0_0_0_1000, // R5 post-ACK interrupt
    15'b0_0000_0_0_0_0_0_1_0100, // R4 release
    15'b0_0000_0_0_1_1_0_0_0100, // R8 transmit keeps wait 0
    15'b1_0111_0_0_1_0_0_0_0100, // R8 transmit no pause
    15'b1_1000_0_0_1_0_0_0_1000, // R5 transmit ACK interrupt
    15'b0_0000_0_0_0_0_0_1_0100, // R4 release
    15'b0_0000_0_0_0_1_0_0_0101, // R7 set wait again
    15'b1_0111_0_0_0_0_0_0_1011, // R3 pause again
    15'b0_0000_0_1_0_0_0_0_1000, // R2 R10 stop: irq, pend kept, hold off
    15'b0_0000_0_0_0_0_0_0_0000  // R2 single-cycle pulse
  };
  localparam string VREQ [NV] = '{"R8","R8","R8","R5","R4","R7","R3","R3","R3",
    "R9","R7","R4","R5","R4","R8","R8","R5","R4","R7","R3","R10","R2"};

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    scl_fall = 0; bit_idx = 0; start_det = 0; stop_det = 0; xmit = 0;
    wr_data = 0; wr_ctrl = 0; wr_cfg = 0; wr_stat = 0; stat_pend = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_reset();
    chk("R1", "pend_n", pend_n, 1'b1);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "scl_hold", scl_hold, 1'b0);
    chk("R1", "wait_flag", wait_flag, 1'b0);
    chk("R1", "wr_err", wr_err, 1'b0);
    chk("R1", "ack_bit", ack_bit, 1'b0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    ctrl_ack_clk = 0; ctrl_ack_bit = 0; cfg_stop_ie = 0; cfg_wait_ie = 0;
    idle();
    do_reset();
    chk_reset();

    // configure: stop irq on, wait on, ACK clock on, ACK bit 1
    wr_cfg = 1; cfg_stop_ie = 1; cfg_wait_ie = 1; step();
    wr_ctrl = 1; ctrl_ack_clk = 1; ctrl_ack_bit = 1; step();
    chk("R7", "ack_bit latched", ack_bit, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      scl_fall = v[14]; bit_idx = v[13:10]; start_det = v[9]; stop_det = v[8];
      xmit = v[7]; wr_data = v[6]; wr_ctrl = v[5]; wr_stat = v[4];
      stat_pend = v[4];
      step();
      chk(VREQ[i], $sformatf("irq v%0d", i), irq, v[3]);
      chk(VREQ[i], $sformatf("pend_n v%0d", i), pend_n, v[2]);
      chk(VREQ[i], $sformatf("scl_hold v%0d", i), scl_hold, v[1]);
      chk(VREQ[i], $sformatf("wait_flag v%0d", i), wait_flag, v[0]);
    end

    // R9: data write during hold latched the sticky error
    chk("R9", "wr_err sticky", wr_err, 1'b1);

    // R4: status write of 0 does nothing
    wr_stat = 1; stat_pend = 0; step();
    chk("R4", "pend_n after write 0", pend_n, 1'b0);

    // R6: no ACK clock, wait enable still 1
    wr_stat = 1; stat_pend = 1; step();
    wr_ctrl = 1; ctrl_ack_clk = 0; ctrl_ack_bit = 0; step();
    chk("R7", "ack_bit 0 latched", ack_bit, 1'b0);
    wr_data = 1; step();
    chk("R7", "wait set no-ack mode", wait_flag, 1'b1);
    scl_fall = 1; bit_idx = 4'd7; step();
    chk("R6", "irq at bit 7", irq, 1'b1);
    chk("R6", "pend_n at bit 7", pend_n, 1'b0);
    chk("R6", "no hold", scl_hold, 1'b0);
    wr_stat = 1; stat_pend = 1; step();
    scl_fall = 1; bit_idx = 4'd8; step();
    chk("R6", "no irq at bit 8", irq, 1'b0);
    chk("R6", "pend_n stays 1", pend_n, 1'b1);

    // R2: stop interrupt disabled
    wr_cfg = 1; cfg_stop_ie = 0; cfg_wait_ie = 1; step();
    stop_det = 1; step();
    chk("R2", "no stop irq when disabled", irq, 1'b0);
    chk("R10", "wait cleared by stop", wait_flag, 1'b0);

    // R1: reset mid-run clears sticky error
    do_reset();
    chk_reset();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule